// File: doc/BRIEF.md
# Interlaced Video Byte-Stream Receiver with Line-Count Check

This block sits behind a digital video decoder and takes its 8-bit stream, one byte per clock, in the format that carries timing reference codes inside the data. It locates those codes, uses the field bit to find the first line of each frame, and from that point packs every byte of the stream, codes and blanking included, into 32-bit words for a downstream DMA engine over a valid/ready handshake. A full NTSC frame of 525 lines of 1716 bytes therefore reaches memory as 429 words per line.

While it receives, the block counts the lines of each frame and compares the count with a programmed frame length, 525 for NTSC. A mismatch sets a sticky frame-tracking error that software clears by writing one to it. The word count of the last completed frame is kept for status reads.

Three small state machines do the work. The sync tracker walks SYNC_HUNT -> SYNC_LEAD (on 0xFF) -> SYNC_ZERO1 (on 0x00) -> SYNC_ZERO2 (on 0x00) and flags a code when the next byte has its top bit set; any other byte sends it back to SYNC_HUNT, or to SYNC_LEAD on a fresh 0xFF. The frame sequencer moves FR_IDLE -> FR_SEEK when enabled, FR_SEEK -> FR_RUN on the first frame start, and back to FR_IDLE from either when the enable drops. The output holder moves HOLD_EMPTY -> HOLD_FULL when a word completes and HOLD_FULL -> HOLD_EMPTY when the word is taken and no new one arrives.

Top module: `vid656_rx`

## Requirements
- R1: During reset `out_valid`, `sts_ftrk_err` and `sts_ovf_err` are 0 and `sts_last_lines` is 0.
- R2: A timing code is the byte run 0xFF, 0x00, 0x00, XY where XY bit 7 is 1; bit 6 is the field flag F, bit 5 the blanking flag V, bit 4 is H (1 = end of active video, the code that opens a line); bits 3..0 and the V flag have no effect on framing or counting.
- R3: A frame starts at an end-of-active code with F = 0 whose preceding code had F = 1; after enable, no word is produced before the first frame start.
- R4: From the 0xFF of the frame-start code on, every byte is packed little-endian, first byte in bits 7..0, and every fourth byte completes one 32-bit word delivered in stream order.
- R5: The line count of a frame is the number of end-of-active codes from its frame start up to the next frame start; it is latched into `sts_last_lines` at that next frame start and is unchanged at all other times.
- R6: At each frame start after the first one since enable, a line count different from `ctl_frame_lines` sets `sts_ftrk_err`, which then stays 1; an equal count leaves it unchanged.
- R7: A one-cycle pulse on `sts_ftrk_clr` clears `sts_ftrk_err` on the next edge unless a mismatch is detected at the same edge.
- R8: A presented word holds `out_data` steady until `out_ready`; a word that completes while one is held and `out_ready` is 0 is dropped and sets sticky `sts_ovf_err`, cleared by a pulse on `sts_ovf_clr`.
- R9: With `ctl_en` low no word is produced and `sts_ftrk_err` is not set; after enable rises the block waits for a new frame start and skips the line-count comparison at that start.
- R10: Each frame start restarts packing at byte lane 0, discarding any partly filled word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| vin_data | input | 8 | Video byte from the decoder, one per clock |
| ctl_en | input | 1 | Receive enable |
| ctl_frame_lines | input | 11 | Expected lines per frame |
| sts_ftrk_clr | input | 1 | Write-one pulse clearing the frame-tracking error |
| sts_ovf_clr | input | 1 | Write-one pulse clearing the overrun error |
| out_data | output | 32 | Packed word to the DMA |
| out_valid | output | 1 | Word on `out_data` is valid |
| out_ready | input | 1 | DMA accepts the word |
| sts_ftrk_err | output | 1 | Sticky line-count mismatch flag |
| sts_ovf_err | output | 1 | Sticky word-dropped flag |
| sts_last_lines | output | 11 | Line count of the last completed frame |

## Verification
The bound checker watches, on every cycle, that a held word stays put under back-pressure, that both error flags stay set until cleared, that a clear takes effect when no frame start competes, that the line-count status moves only at a frame start and that nothing is emitted while disabled. Whether the packed words carry the right bytes in the right order, whether a frame start is recognised only on the correct field change, whether the counted length and the resulting error are right, and how alignment behaves after stray bytes or a re-enable can only be shown by the bench's frame scenarios against its scoreboard.

// File: rtl/vid656_pkg.sv
package vid656_pkg;

    // Bytes of the code preamble ahead of the flag byte
    localparam int TRC_PRE = 3;

    typedef enum logic [1:0] {
        SYNC_HUNT,
        SYNC_LEAD,
        SYNC_ZERO1,
        SYNC_ZERO2
    } sync_st_t;

    typedef enum logic [1:0] {
        FR_IDLE,
        FR_SEEK,
        FR_RUN
    } frm_st_t;

    typedef enum logic {
        HOLD_EMPTY,
        HOLD_FULL
    } hold_st_t;

    // Decoded timing code, valid in the cycle the flag byte is on the input
    typedef struct packed {
        logic hit;
        logic f;
        logic v;
        logic h;
    } trc_t;

endpackage

// File: rtl/vid656_sync.sv
module vid656_sync
    import vid656_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] din,
    output trc_t              trc,
    output logic [BYTE_W-1:0] lag_byte
);

    localparam logic [BYTE_W-1:0] ALL_ONE  = '1;
    localparam logic [BYTE_W-1:0] ALL_ZERO = '0;

    sync_st_t st, st_nx;
    logic [BYTE_W-1:0] lag [TRC_PRE];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= SYNC_HUNT;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = SYNC_HUNT;
        unique case (st)
            SYNC_HUNT:  st_nx = (din == ALL_ONE) ? SYNC_LEAD : SYNC_HUNT;
            SYNC_LEAD:  st_nx = (din == ALL_ONE)  ? SYNC_LEAD  :
                                (din == ALL_ZERO) ? SYNC_ZERO1 : SYNC_HUNT;
            SYNC_ZERO1: st_nx = (din == ALL_ZERO) ? SYNC_ZERO2 :
                                (din == ALL_ONE)  ? SYNC_LEAD  : SYNC_HUNT;
            SYNC_ZERO2: st_nx = (din == ALL_ONE)  ? SYNC_LEAD  : SYNC_HUNT;
            default:    st_nx = SYNC_HUNT;
        endcase
    end

    // Flag byte: top bit set, and not a fresh preamble byte
    always_comb begin
        trc.hit = (st == SYNC_ZERO2) && din[BYTE_W-1] && (din != ALL_ONE);
        trc.f   = din[BYTE_W-2];
        trc.v   = din[BYTE_W-3];
        trc.h   = din[BYTE_W-4];
    end

    // Delay line so the packer sees the preamble's first byte when the code hits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lag[0] <= '0;
        else        lag[0] <= din;
    end

    for (genvar g = 1; g < TRC_PRE; g++) begin : g_lag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) lag[g] <= '0;
            else        lag[g] <= lag[g-1];
        end
    end

    assign lag_byte = lag[TRC_PRE-1];

endmodule

// File: rtl/vid656_frm.sv
module vid656_frm
    import vid656_pkg::*;
#(
    parameter int LINE_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  trc_t              trc,
    input  logic [LINE_W-1:0] frame_lines,
    input  logic              err_clr,
    output logic              frm_start,
    output logic              pack_run,
    output logic              err,
    output logic [LINE_W-1:0] last_lines
);

    localparam logic [LINE_W-1:0] CNT_MAX = '1;
    localparam logic [LINE_W-1:0] CNT_ONE = LINE_W'(1);

    frm_st_t st, st_nx;
    logic prev_f;
    logic is_eav, boundary, compare, mismatch;
    logic [LINE_W-1:0] line_cnt;

    assign is_eav   = trc.hit && trc.h;
    assign boundary = is_eav && !trc.f && prev_f;

    // Field flag of the most recent code, tracked even while disabled
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       prev_f <= 1'b0;
        else if (trc.hit) prev_f <= trc.f;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= FR_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = FR_IDLE;
        unique case (st)
            FR_IDLE: st_nx = en ? FR_SEEK : FR_IDLE;
            FR_SEEK: st_nx = !en ? FR_IDLE : (boundary ? FR_RUN : FR_SEEK);
            FR_RUN:  st_nx = en ? FR_RUN : FR_IDLE;
            default: st_nx = FR_IDLE;
        endcase
    end

    always_comb begin
        frm_start = en && boundary && (st == FR_SEEK || st == FR_RUN);
        pack_run  = en && (st == FR_RUN);
        compare   = en && boundary && (st == FR_RUN);
        mismatch  = compare && (line_cnt != frame_lines);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_cnt <= '0;
        end else if (frm_start) begin
            line_cnt <= CNT_ONE;
        end else if (pack_run && is_eav && line_cnt != CNT_MAX) begin
            line_cnt <= line_cnt + CNT_ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       last_lines <= '0;
        else if (compare) last_lines <= line_cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        err <= 1'b0;
        else if (mismatch) err <= 1'b1;
        else if (err_clr)  err <= 1'b0;
    end

endmodule

// File: rtl/vid656_pack.sv
module vid656_pack
    import vid656_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int LANES  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic                    run,
    input  logic [BYTE_W-1:0]       byte_in,
    input  logic                    out_ready,
    input  logic                    ovf_clr,
    output logic [BYTE_W*LANES-1:0] out_data,
    output logic                    out_valid,
    output logic                    ovf_err
);

    localparam int WORD_W = BYTE_W * LANES;
    localparam int LANE_W = (LANES > 2) ? $clog2(LANES) : 1;
    localparam logic [LANE_W-1:0] LAST = LANE_W'(LANES - 1);
    localparam logic [LANE_W-1:0] ONE  = LANE_W'(1);

    logic [LANE_W-1:0] lane;
    logic [BYTE_W-1:0] acc [LANES-1];
    logic [WORD_W-1:0] word;
    logic              word_done;
    hold_st_t          hst, hst_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     lane <= '0;
        else if (start) lane <= ONE;
        else if (run)   lane <= (lane == LAST) ? '0 : lane + ONE;
        else            lane <= '0;
    end

    for (genvar g = 0; g < LANES - 1; g++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                acc[g] <= '0;
            else if (start && g == 0)
                acc[g] <= byte_in;
            else if (!start && run && lane == LANE_W'(g))
                acc[g] <= byte_in;
        end
        assign word[g*BYTE_W +: BYTE_W] = acc[g];
    end

    assign word[WORD_W-1 -: BYTE_W] = byte_in;
    assign word_done = run && !start && (lane == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hst <= HOLD_EMPTY;
        else        hst <= hst_nx;
    end

    always_comb begin
        hst_nx = HOLD_EMPTY;
        unique case (hst)
            HOLD_EMPTY: hst_nx = word_done ? HOLD_FULL : HOLD_EMPTY;
            HOLD_FULL:  hst_nx = (out_ready && !word_done) ? HOLD_EMPTY : HOLD_FULL;
            default:    hst_nx = HOLD_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            out_data <= '0;
        else if (word_done && (hst == HOLD_EMPTY || out_ready))
            out_data <= word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ovf_err <= 1'b0;
        else if (word_done && hst == HOLD_FULL && !out_ready)
            ovf_err <= 1'b1;
        else if (ovf_clr)
            ovf_err <= 1'b0;
    end

    assign out_valid = (hst == HOLD_FULL);

endmodule

// File: rtl/vid656_rx.sv
module vid656_rx
    import vid656_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int LANES  = 4,
    parameter int LINE_W = 11
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [BYTE_W-1:0]       vin_data,
    input  logic                    ctl_en,
    input  logic [LINE_W-1:0]       ctl_frame_lines,
    input  logic                    sts_ftrk_clr,
    input  logic                    sts_ovf_clr,
    output logic [BYTE_W*LANES-1:0] out_data,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic                    sts_ftrk_err,
    output logic                    sts_ovf_err,
    output logic [LINE_W-1:0]       sts_last_lines
);

    trc_t              trc;
    logic [BYTE_W-1:0] lag_byte;
    logic              frm_start;
    logic              pack_run;

    vid656_sync #(.BYTE_W(BYTE_W)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (vin_data),
        .trc      (trc),
        .lag_byte (lag_byte)
    );

    vid656_frm #(.LINE_W(LINE_W)) u_frm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (ctl_en),
        .trc         (trc),
        .frame_lines (ctl_frame_lines),
        .err_clr     (sts_ftrk_clr),
        .frm_start   (frm_start),
        .pack_run    (pack_run),
        .err         (sts_ftrk_err),
        .last_lines  (sts_last_lines)
    );

    vid656_pack #(.BYTE_W(BYTE_W), .LANES(LANES)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (frm_start),
        .run       (pack_run),
        .byte_in   (lag_byte),
        .out_ready (out_ready),
        .ovf_clr   (sts_ovf_clr),
        .out_data  (out_data),
        .out_valid (out_valid),
        .ovf_err   (sts_ovf_err)
    );

endmodule

// File: rtl/vid656_rx_chk.sv
module vid656_rx_chk #(
    parameter int BYTE_W = 8,
    parameter int LANES  = 4,
    parameter int LINE_W = 11
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    ctl_en,
    input logic                    sts_ftrk_clr,
    input logic                    sts_ovf_clr,
    input logic [BYTE_W*LANES-1:0] out_data,
    input logic                    out_valid,
    input logic                    out_ready,
    input logic                    sts_ftrk_err,
    input logic                    sts_ovf_err,
    input logic [LINE_W-1:0]       sts_last_lines,
    input logic                    frm_start
);

    // R8
    hold_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    // R8
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sts_ovf_err && !sts_ovf_clr |=> sts_ovf_err);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_en && !out_valid |=> !out_valid);

    // R6
    ftrk_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sts_ftrk_err && !sts_ftrk_clr |=> sts_ftrk_err);

    // R6
    ftrk_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_ftrk_err) |-> $past(frm_start));

    // R7
    ftrk_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sts_ftrk_clr && !frm_start |=> !sts_ftrk_err);

    // R5
    lines_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_start |=> $stable(sts_last_lines));

endmodule

bind vid656_rx vid656_rx_chk #(
    .BYTE_W (BYTE_W),
    .LANES  (LANES),
    .LINE_W (LINE_W)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .ctl_en         (ctl_en),
    .sts_ftrk_clr   (sts_ftrk_clr),
    .sts_ovf_clr    (sts_ovf_clr),
    .out_data       (out_data),
    .out_valid      (out_valid),
    .out_ready      (out_ready),
    .sts_ftrk_err   (sts_ftrk_err),
    .sts_ovf_err    (sts_ovf_err),
    .sts_last_lines (sts_last_lines),
    .frm_start      (frm_start)
);

// File: tb/sim_vid656_rx.sv
`timescale 1ns/1ps
module sim_vid656_rx;

    localparam int BYTE_W = 8;
    localparam int LANES  = 4;
    localparam int LINE_W = 11;
    localparam int WORD_W = BYTE_W * LANES;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [BYTE_W-1:0] din = 8'h10;
    logic              en = 1'b0;
    logic [LINE_W-1:0] flen = 11'd10;
    logic              fclr = 1'b0;
    logic              oclr = 1'b0;
    logic              rdy = 1'b1;
    logic [WORD_W-1:0] out_data;
    logic              out_valid;
    logic              ftrk_err;
    logic              ovf_err;
    logic [LINE_W-1:0] last_lines;

    always #2.5 clk = ~clk;

    vid656_rx #(.BYTE_W(BYTE_W), .LANES(LANES), .LINE_W(LINE_W)) u0 (
        .clk             (clk),
        .rst_n           (rst_n),
        .vin_data        (din),
        .ctl_en          (en),
        .ctl_frame_lines (flen),
        .sts_ftrk_clr    (fclr),
        .sts_ovf_clr     (oclr),
        .out_data        (out_data),
        .out_valid       (out_valid),
        .out_ready       (rdy),
        .sts_ftrk_err    (ftrk_err),
        .sts_ovf_err     (ovf_err),
        .sts_last_lines  (last_lines)
    );

    int n_chk = 0;
    int n_bad = 0;
    logic [WORD_W-1:0] expq[$];
    bit sb_on   = 1'b1;
    bit rdy_pat = 1'b0;
    int cyc     = 0;
    int lc      = 0;
    bit pend_fclr = 1'b0;
    bit pend_oclr = 1'b0;

    // Reference model state
    bit       m_on   = 1'b0;
    logic [7:0] m_b [4];
    int       m_n    = 0;
    bit       m_pf   = 1'b0;
    bit       m_arm  = 1'b0;
    int       m_lines = 0;
    int       m_last = 0;
    bit       m_ferr = 1'b0;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        din  = b;
        fclr = pend_fclr;
        oclr = pend_oclr;
        pend_fclr = 1'b0;
        pend_oclr = 1'b0;
        cyc++;
        if (rdy_pat) rdy = (cyc % 3 != 0);
        if (m_on) begin
            m_b[m_n] = b;
            m_n++;
            if (m_n == 4) begin
                if (sb_on) expq.push_back({m_b[3], m_b[2], m_b[1], m_b[0]});
                m_n = 0;
            end
        end
    endtask

    task automatic set_en(input bit v);
        @(negedge clk);
        en = v;
        if (!v) begin
            // bytes still in the 3-deep preamble delay are never packed
            if (m_on && m_n < 3 && sb_on && expq.size() > 0) void'(expq.pop_back());
            m_on  = 1'b0;
            m_arm = 1'b0;
            m_n   = 0;
        end
    endtask

    task automatic send_trc(input bit f, input bit v, input bit h, input bit good);
        logic [7:0] xy;
        xy = {1'b1, f, v, h, good ? {v ^ h, f ^ h, f ^ v, f ^ v ^ h} : 4'h0};
        if (h && !f && m_pf && en) begin
            if (m_arm) begin
                m_last = m_lines;
                if (m_lines != int'(flen)) m_ferr = 1'b1;
            end
            m_arm   = 1'b1;
            m_lines = 1;
            m_on    = 1'b1;
            m_n     = 0;
        end else if (h && m_arm) begin
            m_lines++;
        end
        m_pf = f;
        put(8'hFF); put(8'h00); put(8'h00); put(xy);
    endtask

    task automatic send_line(input bit f, input bit v, input bit good);
        send_trc(f, v, 1'b1, good);
        put(8'h80); put(8'h10); put(8'h80); put(8'h10);
        send_trc(f, v, 1'b0, good);
        for (int i = 0; i < 8; i++) put(8'(8'h40 + ((lc * 8 + i) % 128)));
        lc++;
    endtask

    task automatic send_frame(input int n, input bit v, input bit good);
        for (int i = 0; i < n; i++) send_line((i < (n + 1) / 2) ? 1'b0 : 1'b1, v && (i % 3 == 0), good);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && out_valid && rdy && sb_on) begin
                if (expq.size() == 0) begin
                    n_chk++;
                    n_bad++;
                    $display("FAIL R4 actual=%0h expected=<none>", out_data);
                end else begin
                    check("R4 word", out_data, expq.pop_front());
                end
            end
        end
    end

    // Watchdog
    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        // R1 reset state
        check("R1 valid", out_valid, 0);
        check("R1 ftrk", ftrk_err, 0);
        check("R1 ovf", ovf_err, 0);
        check("R1 lines", last_lines, 0);
        @(negedge clk); rst_n = 1'b1;

        set_en(1'b1);
        // R3: field-2 lines before any frame start produce nothing
        send_line(1'b1, 1'b0, 1'b1);
        send_line(1'b1, 1'b0, 1'b1);
        check("R3 no word before start", out_valid, 0);

        send_frame(10, 1'b0, 1'b1);
        send_frame(10, 1'b0, 1'b1);
        send_frame(10, 1'b0, 1'b1);
        check("R5 last lines", last_lines, m_last);
        check("R6 match keeps clear", ftrk_err, m_ferr);

        // R6 short frame
        send_frame(9, 1'b0, 1'b1);
        send_frame(10, 1'b0, 1'b1);
        check("R6 mismatch sets", ftrk_err, 1);
        check("R5 short count", last_lines, 9);
        // R7 clear
        pend_fclr = 1'b1; m_ferr = 1'b0;
        send_frame(10, 1'b0, 1'b1);
        check("R7 cleared", ftrk_err, 0);
        check("R5 count back", last_lines, 10);

        // R8 back-pressure pattern
        rdy_pat = 1'b1;
        send_frame(10, 1'b0, 1'b1);
        send_frame(10, 1'b0, 1'b1);
        rdy_pat = 1'b0;
        @(negedge clk); rdy = 1'b1;

        // R2 protection bits and V flag ignored
        send_frame(10, 1'b1, 1'b0);
        send_frame(10, 1'b0, 1'b1);
        check("R2 count with odd flags", last_lines, 10);
        check("R2 no error", ftrk_err, 0);

        // R10 stray bytes before a frame start
        put(8'h80); put(8'h10);
        send_frame(10, 1'b0, 1'b1);
        send_frame(10, 1'b0, 1'b1);
        check("R10 count", last_lines, 10);

        // R9 disable: no words, no error even on a wrong-length frame
        set_en(1'b0);
        idle(8);
        check("R4 drained", expq.size(), 0);
        send_frame(7, 1'b0, 1'b1);
        send_frame(7, 1'b0, 1'b1);
        check("R9 no word while off", out_valid, 0);
        check("R9 no error while off", ftrk_err, 0);
        send_line(1'b0, 1'b0, 1'b1);
        send_line(1'b0, 1'b0, 1'b1);
        set_en(1'b1);
        send_line(1'b0, 1'b0, 1'b1);
        send_line(1'b1, 1'b0, 1'b1);
        check("R9 waits for frame start", out_valid, 0);
        flen = 11'd8;
        send_frame(10, 1'b0, 1'b1);
        check("R9 first start skips compare", ftrk_err, 0);
        send_frame(8, 1'b0, 1'b1);
        send_frame(8, 1'b0, 1'b1);
        check("R6 new length", last_lines, 8);
        check("R6 new length no error", ftrk_err, m_ferr);

        // R8 overrun
        set_en(1'b0);
        idle(8);
        check("R4 all words seen", expq.size(), 0);
        sb_on = 1'b0;
        @(negedge clk); rdy = 1'b0;
        set_en(1'b1);
        send_line(1'b1, 1'b0, 1'b1);
        send_line(1'b0, 1'b0, 1'b1);
        send_line(1'b0, 1'b0, 1'b1);
        check("R8 held first word", out_data, 32'h9D0000FF);
        check("R8 held valid", out_valid, 1);
        check("R8 overrun set", ovf_err, 1);
        set_en(1'b0);
        pend_oclr = 1'b1;
        put(8'h10); put(8'h10);
        check("R8 overrun cleared", ovf_err, 0);
        @(negedge clk); rdy = 1'b1;
        idle(3);
        check("R8 word taken", out_valid, 0);
        sb_on = 1'b1;

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule